// File: doc/BRIEF.md
# Descriptor Table Address Unit

This block keeps the three descriptor-table pointer registers of a protected-mode address path: one for the global table, one for the local table and one for the interrupt table. Each register pairs a 32-bit linear base address with a 16-bit limit. The limit is the byte offset of the last valid byte in the table. Software-level commands write a register, but only when the current privilege level is 0. Separate commands read a register back.

The lookup side takes either a 16-bit selector or an 8-bit interrupt vector. For a selector, the unit picks the global or local table from selector bit 2 and takes the index from the upper 13 bits. For a vector, it indexes the interrupt table directly. It then forms the linear address of the 8-byte descriptor, which is base + index*8. The address is checked against the table limit. One clock after the request, the unit reports either an address strobe or a fault strobe, and the fault carries its cause. The unit does not fetch the descriptor itself; that is left to the memory path that follows.

Top module: `dtab_addr_unit`

## Requirements
- R1: After reset, every base and every limit reads as zero. All output strobes (addrValid, faultValid, loadDone, readValid) are low.
- R2: A load with loadEn high, curPriv equal to 0 and loadSel 0 (global), 1 (local) or 2 (interrupt) writes loadBase and loadLimit into that register. loadDone pulses high one cycle later.
- R3: A load with curPriv not equal to 0 and loadSel in 0..2 is refused and the register keeps its value. One cycle later, faultValid is high with faultCause bit 0 (privilege) set, and loadDone stays low.
- R4: readEn with readSel 0..2 returns that register's base and limit on readBase/readLimit one cycle later, with readValid high. readSel 3 returns zeros with readValid high.
- R5: A selector lookup (lkValid high, lkIntr low) uses lkSelector[15:3] as the index. Bit 2 picks the table: 0 for global, 1 for local. Bits 1:0 have no effect. The address is base + index*8.
- R6: An interrupt lookup (lkIntr high) uses lkVector as the index into the interrupt table and ignores lkSelector.
- R7: A lookup whose index*8+7 exceeds the table limit faults. faultValid is high with faultCause bit 1 (limit) set, addrValid stays low and addrOut is zero. After reset every lookup faults this way.
- R8: A lookup whose index*8+7 equals the limit exactly succeeds.
- R9: Every response appears exactly one cycle after its request. A lookup issued in the same cycle as a load to its table uses the value held before that load.
- R10: The address sum wraps modulo 2^32.
- R11: A load with loadSel 3 has no effect at any privilege level. It produces no loadDone and no fault, and all registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curPriv | input | 2 | Current privilege level, 0 most privileged |
| loadEn | input | 1 | Load request |
| loadSel | input | 2 | Register to load: 0 global, 1 local, 2 interrupt, 3 none |
| loadBase | input | 32 | Base address to load |
| loadLimit | input | 16 | Limit to load |
| readEn | input | 1 | Read-back request |
| readSel | input | 2 | Register to read, same coding as loadSel |
| lkValid | input | 1 | Lookup request |
| lkIntr | input | 1 | 1: interrupt-vector lookup, 0: selector lookup |
| lkSelector | input | 16 | Selector for selector lookups |
| lkVector | input | 8 | Vector for interrupt lookups |
| loadDone | output | 1 | Load accepted and written |
| readValid | output | 1 | Read-back data valid |
| readBase | output | 32 | Read-back base |
| readLimit | output | 16 | Read-back limit |
| addrValid | output | 1 | Descriptor address valid |
| addrOut | output | 32 | Linear descriptor address |
| faultValid | output | 1 | Fault strobe |
| faultCause | output | 2 | Bit 0 privilege refusal, bit 1 limit violation |

## Verification
The bound checker enforces several relations on every cycle. Each lookup yields exactly one of an address or a limit fault, never both. A refused load always raises the privilege cause and never a loadDone. Read, load and address strobes only follow a request of their own kind one cycle earlier. Other properties depend on values held in registers across many cycles, and only the bench scenarios can show them. These are the actual address values, the exact limit boundary, wrap-around of the sum, the old-value rule when a load and a lookup meet, and the fact that a refused or ignored load leaves a register unchanged.

// File: rtl/dtab_pkg.sv
package dtab_pkg;

  localparam int NUM_TABLES = 3;

  typedef enum logic [1:0] {
    TBL_GLOBAL = 2'd0,
    TBL_LOCAL  = 2'd1,
    TBL_INTR   = 2'd2,
    TBL_NONE   = 2'd3
  } tableSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_TABLES-1:0] wrTable;
    logic                  privDeny;
    logic                  lookupGo;
    tableSel_t             lookupTable;
    logic                  readGo;
  } ctrlStrobes_t;

endpackage

// File: rtl/dtab_ctrl.sv
module dtab_ctrl
  import dtab_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int TI_BIT = 2
) (
  input  logic             loadEn,
  input  logic [1:0]       loadSel,
  input  logic [1:0]       curPriv,
  input  logic             readEn,
  input  logic             lkValid,
  input  logic             lkIntr,
  input  logic [SEL_W-1:0] lkSelector,
  output ctrlStrobes_t     strobes
);

  logic loadTargetOk;
  logic privOk;

  assign loadTargetOk = (loadSel != TBL_NONE);
  assign privOk       = (curPriv == 2'd0);

  always_comb begin
    strobes          = '0;
    strobes.privDeny = loadEn && loadTargetOk && !privOk;
    for (int t = 0; t < NUM_TABLES; t++) begin
      strobes.wrTable[t] = loadEn && privOk && (loadSel == 2'(t));
    end
    strobes.readGo   = readEn;
    strobes.lookupGo = lkValid;
    if (lkIntr) begin
      strobes.lookupTable = TBL_INTR;
    end else if (lkSelector[TI_BIT]) begin
      strobes.lookupTable = TBL_LOCAL;
    end else begin
      strobes.lookupTable = TBL_GLOBAL;
    end
  end

endmodule

// File: rtl/dtab_datapath.sv
module dtab_datapath
  import dtab_pkg::*;
#(
  parameter int BASE_W  = 32,
  parameter int LIMIT_W = 16,
  parameter int SEL_W   = 16,
  parameter int VEC_W   = 8,
  parameter int STRIDE_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [BASE_W-1:0]  loadBase,
  input  logic [LIMIT_W-1:0] loadLimit,
  input  logic [1:0]         readSel,
  input  logic [SEL_W-1:0]   lkSelector,
  input  logic [VEC_W-1:0]   lkVector,
  output logic               loadDone,
  output logic               readValid,
  output logic [BASE_W-1:0]  readBase,
  output logic [LIMIT_W-1:0] readLimit,
  output logic               addrValid,
  output logic [BASE_W-1:0]  addrOut,
  output logic               faultValid,
  output logic [1:0]         faultCause
);

  localparam int IDX_W = SEL_W - STRIDE_LOG2;
  localparam int OFF_W = IDX_W + STRIDE_LOG2;
  localparam int CMP_W = (OFF_W > LIMIT_W) ? OFF_W : LIMIT_W;

  logic [BASE_W-1:0]  baseReg  [NUM_TABLES];
  logic [LIMIT_W-1:0] limitReg [NUM_TABLES];

  // table registers, one write port each
  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_table
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseReg[t]  <= '0;
        limitReg[t] <= '0;
      end else if (strobes.wrTable[t]) begin
        baseReg[t]  <= loadBase;
        limitReg[t] <= loadLimit;
      end
    end
  end

  // index extraction
  logic [IDX_W-1:0]   index;
  logic [OFF_W-1:0]   offset;
  logic [CMP_W-1:0]   lastByte;
  logic [CMP_W-1:0]   limitExt;
  logic [BASE_W-1:0]  selBase;
  logic [LIMIT_W-1:0] selLimit;
  logic [BASE_W-1:0]  descAddr;
  logic               overLimit;

  always_comb begin
    if (strobes.lookupTable == TBL_INTR) begin
      index = IDX_W'(lkVector);
    end else begin
      index = lkSelector[SEL_W-1:STRIDE_LOG2];
    end
    offset = {index, {STRIDE_LOG2{1'b0}}};
  end

  always_comb begin
    selBase  = '0;
    selLimit = '0;
    for (int t = 0; t < NUM_TABLES; t++) begin
      if (strobes.lookupTable == tableSel_t'(t)) begin
        selBase  = baseReg[t];
        selLimit = limitReg[t];
      end
    end
  end

  assign lastByte  = CMP_W'(offset) | CMP_W'({STRIDE_LOG2{1'b1}});
  assign limitExt  = CMP_W'(selLimit);
  assign overLimit = lastByte > limitExt;
  assign descAddr  = selBase + BASE_W'(offset);

  // read-back mux
  logic [BASE_W-1:0]  rdBaseMux;
  logic [LIMIT_W-1:0] rdLimitMux;

  always_comb begin
    rdBaseMux  = '0;
    rdLimitMux = '0;
    for (int t = 0; t < NUM_TABLES; t++) begin
      if (readSel == 2'(t)) begin
        rdBaseMux  = baseReg[t];
        rdLimitMux = limitReg[t];
      end
    end
  end

  logic lookupOk;
  logic lookupBad;
  assign lookupOk  = strobes.lookupGo && !overLimit;
  assign lookupBad = strobes.lookupGo && overLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadDone   <= 1'b0;
      readValid  <= 1'b0;
      readBase   <= '0;
      readLimit  <= '0;
      addrValid  <= 1'b0;
      addrOut    <= '0;
      faultValid <= 1'b0;
      faultCause <= '0;
    end else begin
      loadDone   <= |strobes.wrTable;
      readValid  <= strobes.readGo;
      readBase   <= strobes.readGo ? rdBaseMux : '0;
      readLimit  <= strobes.readGo ? rdLimitMux : '0;
      addrValid  <= lookupOk;
      addrOut    <= lookupOk ? descAddr : '0;
      faultValid <= lookupBad || strobes.privDeny;
      faultCause <= {lookupBad, strobes.privDeny};
    end
  end

endmodule

// File: rtl/dtab_addr_unit.sv
module dtab_addr_unit
  import dtab_pkg::*;
#(
  parameter int BASE_W  = 32,
  parameter int LIMIT_W = 16,
  parameter int SEL_W   = 16,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         curPriv,
  input  logic               loadEn,
  input  logic [1:0]         loadSel,
  input  logic [BASE_W-1:0]  loadBase,
  input  logic [LIMIT_W-1:0] loadLimit,
  input  logic               readEn,
  input  logic [1:0]         readSel,
  input  logic               lkValid,
  input  logic               lkIntr,
  input  logic [SEL_W-1:0]   lkSelector,
  input  logic [VEC_W-1:0]   lkVector,
  output logic               loadDone,
  output logic               readValid,
  output logic [BASE_W-1:0]  readBase,
  output logic [LIMIT_W-1:0] readLimit,
  output logic               addrValid,
  output logic [BASE_W-1:0]  addrOut,
  output logic               faultValid,
  output logic [1:0]         faultCause
);

  ctrlStrobes_t strobes;

  dtab_ctrl #(.SEL_W(SEL_W), .TI_BIT(2)) ctrl_i (
    .loadEn     (loadEn),
    .loadSel    (loadSel),
    .curPriv    (curPriv),
    .readEn     (readEn),
    .lkValid    (lkValid),
    .lkIntr     (lkIntr),
    .lkSelector (lkSelector),
    .strobes    (strobes)
  );

  dtab_datapath #(
    .BASE_W(BASE_W), .LIMIT_W(LIMIT_W), .SEL_W(SEL_W),
    .VEC_W(VEC_W), .STRIDE_LOG2(3)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .loadBase   (loadBase),
    .loadLimit  (loadLimit),
    .readSel    (readSel),
    .lkSelector (lkSelector),
    .lkVector   (lkVector),
    .loadDone   (loadDone),
    .readValid  (readValid),
    .readBase   (readBase),
    .readLimit  (readLimit),
    .addrValid  (addrValid),
    .addrOut    (addrOut),
    .faultValid (faultValid),
    .faultCause (faultCause)
  );

endmodule

// File: rtl/dtab_checker.sv
module dtab_checker #(
  parameter int BASE_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        curPriv,
  input logic              loadEn,
  input logic [1:0]        loadSel,
  input logic              readEn,
  input logic              lkValid,
  input logic              loadDone,
  input logic              readValid,
  input logic              addrValid,
  input logic [BASE_W-1:0] addrOut,
  input logic              faultValid,
  input logic [1:0]        faultCause
);

  // refused load raises the privilege cause and never completes
  assert_priv_refuse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && curPriv != 2'd0 && loadSel != 2'd3) |=> (faultValid && faultCause[0] && !loadDone));

  // loadDone only follows an accepted load
  assert_load_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> $past(loadEn && curPriv == 2'd0 && loadSel != 2'd3));

  // ignored load target: nothing reported
  assert_none_target_R11: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && loadSel == 2'd3 && !lkValid) |=> (!loadDone && !faultValid));

  // each lookup yields exactly one of address or limit fault, one cycle later
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (addrValid ^ faultCause[1]));

  assert_addr_needs_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid || faultCause[1]) |-> $past(lkValid));

  // a limit fault issues no address
  assert_fault_no_addr_R7: assert property (@(posedge clk) disable iff (!rstN)
    faultCause[1] |-> (!addrValid && addrOut == '0));

  assert_read_timing_R4: assert property (@(posedge clk) disable iff (!rstN)
    readValid |-> $past(readEn));

endmodule

bind dtab_addr_unit dtab_checker #(.BASE_W(BASE_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .curPriv    (curPriv),
  .loadEn     (loadEn),
  .loadSel    (loadSel),
  .readEn     (readEn),
  .lkValid    (lkValid),
  .loadDone   (loadDone),
  .readValid  (readValid),
  .addrValid  (addrValid),
  .addrOut    (addrOut),
  .faultValid (faultValid),
  .faultCause (faultCause)
);

// File: tb/dtab_addr_unit_tb_top.sv
`timescale 1ns/1ps
module dtab_addr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  curPriv = '0;
  logic        loadEn = 1'b0;
  logic [1:0]  loadSel = '0;
  logic [31:0] loadBase = '0;
  logic [15:0] loadLimit = '0;
  logic        readEn = 1'b0;
  logic [1:0]  readSel = '0;
  logic        lkValid = 1'b0;
  logic        lkIntr = 1'b0;
  logic [15:0] lkSelector = '0;
  logic [7:0]  lkVector = '0;
  logic        loadDone, readValid, addrValid, faultValid;
  logic [31:0] readBase, addrOut;
  logic [15:0] readLimit;
  logic [1:0]  faultCause;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  dtab_addr_unit dut_i (
    .clk(clk), .rstN(rstN), .curPriv(curPriv),
    .loadEn(loadEn), .loadSel(loadSel), .loadBase(loadBase), .loadLimit(loadLimit),
    .readEn(readEn), .readSel(readSel),
    .lkValid(lkValid), .lkIntr(lkIntr), .lkSelector(lkSelector), .lkVector(lkVector),
    .loadDone(loadDone), .readValid(readValid), .readBase(readBase), .readLimit(readLimit),
    .addrValid(addrValid), .addrOut(addrOut), .faultValid(faultValid), .faultCause(faultCause)
  );

  // lookup vectors: intr, selector, vector, expect fault, expect address
  localparam int NVEC = 9;
  localparam logic        V_INTR [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [15:0] V_SEL  [NVEC] = '{16'h0000, 16'h0003, 16'h00F8, 16'h0100, 16'h001C,
                                            16'hFFFC, 16'h0000, 16'hFFFF, 16'h0004};
  localparam logic [7:0]  V_VEC  [NVEC] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                            8'h00, 8'h00, 8'hFF, 8'h21};
  localparam logic        V_FLT  [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [31:0] V_ADDR [NVEC] = '{32'h0010_0000, 32'h0010_0000, 32'h0010_00F8, 32'h0,
                                            32'h0000_0008, 32'h0000_FFE8, 32'h0000_8000,
                                            32'h0000_87F8, 32'h0000_8108};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doLoad(input logic [1:0] pl, input logic [1:0] sel,
                        input logic [31:0] b, input logic [15:0] l);
    @(negedge clk);
    curPriv = pl; loadEn = 1'b1; loadSel = sel; loadBase = b; loadLimit = l;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] sel, input logic [31:0] eb,
                        input logic [15:0] el, input string req);
    @(negedge clk);
    readEn = 1'b1; readSel = sel;
    @(negedge clk);
    readEn = 1'b0;
    chk(req, 32'(readValid), 32'd1);
    chk(req, readBase, eb);
    chk(req, 32'(readLimit), 32'(el));
  endtask

  task automatic doLookup(input logic intr, input logic [15:0] sel, input logic [7:0] vec,
                          input logic expFault, input logic [31:0] expAddr, input string req);
    @(negedge clk);
    lkValid = 1'b1; lkIntr = intr; lkSelector = sel; lkVector = vec;
    @(negedge clk);
    lkValid = 1'b0;
    chk(req, 32'(addrValid), 32'(!expFault));
    chk(req, 32'(faultCause), expFault ? 32'd2 : 32'd0);
    chk(req, addrOut, expAddr);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 strobes", {28'd0, loadDone, readValid, addrValid, faultValid}, 32'd0);
    doRead(2'd0, 32'h0, 16'h0, "R1 global");
    doRead(2'd1, 32'h0, 16'h0, "R1 local");
    doRead(2'd2, 32'h0, 16'h0, "R1 intr");
    doLookup(1'b0, 16'h0000, 8'h00, 1'b1, 32'h0, "R1 R7 zero limit");

    // R2 configure all three tables at level 0
    doLoad(2'd0, 2'd0, 32'h0010_0000, 16'h00FF);
    chk("R2 loadDone", 32'(loadDone), 32'd1);
    doLoad(2'd0, 2'd1, 32'hFFFF_FFF0, 16'hFFFF);
    doLoad(2'd0, 2'd2, 32'h0000_8000, 16'h07FF);
    doRead(2'd1, 32'hFFFF_FFF0, 16'hFFFF, "R2 R4 local");
    doRead(2'd2, 32'h0000_8000, 16'h07FF, "R2 R4 intr");

    // vector walk: R5 R6 R7 R8 R10
    for (int i = 0; i < NVEC; i++) begin
      doLookup(V_INTR[i], V_SEL[i], V_VEC[i], V_FLT[i], V_ADDR[i], "R5 R6 R7 R8 R10 vector");
    end

    // R9 same-cycle load and lookup sees old value
    @(negedge clk);
    curPriv = 2'd0; loadEn = 1'b1; loadSel = 2'd0;
    loadBase = 32'h2000_0000; loadLimit = 16'h0007;
    lkValid = 1'b1; lkIntr = 1'b0; lkSelector = 16'h0008;
    @(negedge clk);
    loadEn = 1'b0; lkValid = 1'b0;
    chk("R9 old value", addrOut, 32'h0010_0008);
    chk("R9 valid", 32'(addrValid), 32'd1);
    doLookup(1'b0, 16'h0008, 8'h00, 1'b1, 32'h0, "R9 R7 new limit");
    doLookup(1'b0, 16'h0000, 8'h00, 1'b0, 32'h2000_0000, "R9 R8 new base");

    // R3 refused loads
    doLoad(2'd3, 2'd0, 32'hDEAD_0000, 16'hFFFF);
    chk("R3 fault", {29'd0, faultValid, faultCause}, {29'd0, 1'b1, 2'b01});
    chk("R3 no done", 32'(loadDone), 32'd0);
    doLoad(2'd1, 2'd2, 32'hBEEF_0000, 16'h0001);
    chk("R3 fault pl1", 32'(faultCause), 32'd1);
    doRead(2'd0, 32'h2000_0000, 16'h0007, "R3 global kept");
    doRead(2'd2, 32'h0000_8000, 16'h07FF, "R3 intr kept");

    // R11 load to code 3 ignored
    doLoad(2'd0, 2'd3, 32'h1234_5678, 16'h1111);
    chk("R11 nothing", {30'd0, loadDone, faultValid}, 32'd0);
    doRead(2'd0, 32'h2000_0000, 16'h0007, "R11 global kept");
    doRead(2'd1, 32'hFFFF_FFF0, 16'hFFFF, "R11 local kept");
    doRead(2'd3, 32'h0, 16'h0, "R4 code 3 zero");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule